// File: doc/BRIEF.md
# Instruction Address Sequencer with Two-Level Return Stack

This block produces the instruction address for a small 4-bit controller. It holds a 9-bit address into a 512-word instruction store. On every enabled instruction cycle it loads a new address. Under a command from the decoder, that address is the next sequential one, a jump inside the current 64-word page, an absolute jump, a subroutine entry or a subroutine return.

Subroutine linkage uses exactly two dedicated save registers, which work as a last-in, first-out stack. A call pushes the address that follows the current one, and a return pops it. When a third call is nested, the oldest entry is discarded without any indication. Instruction decode and the instruction store are outside this block.

Top module: `pc_seq`

## Requirements
- R1: A synchronous reset sets `pc_o` to 0 and clears both save registers, so a return issued straight after reset yields address 0.
- R2: While `step_en` is 0 the address and both save registers keep their values, whatever `cmd` and `target` carry.
- R3: Command 0 (step) loads the current address plus one, and the address wraps from 511 to 0.
- R4: Command 1 (page jump) keeps address bits [8:6] and loads bits [5:0] from `target[5:0]`.
- R5: Command 2 (absolute jump) loads all 9 bits of `target`.
- R6: Command 3 (call) loads `target` and pushes the current address plus one as the return address, wrapping 511 to 0. The previous top entry moves to the second level.
- R7: Command 4 (return) loads the top save register, and the second-level entry becomes the top. The second level keeps its value.
- R8: Two nested calls followed by two returns come back to the two return addresses in reverse order of the calls.
- R9: A third nested call overwrites the oldest entry with no flag. Three returns then yield the newest return address, then the middle one, then the middle one again.
- R10: Command codes 5, 6 and 7 behave as the step command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Instruction cycle enable |
| cmd | input | 3 | Address command: 0 step, 1 page jump, 2 absolute jump, 3 call, 4 return |
| target | input | ADDR_W | Jump or call target |
| pc_o | output | ADDR_W | Current instruction address |

## Verification
The bench builds the block with its default parameters: a 9-bit address and 64-word pages. With these values, a single absolute jump places the address next to the 511-to-0 wrap, both for stepping and for the return address of a call. Page bits and offset bits can be told apart in one page jump. Because the stack has only two levels, a third nested call reaches the overwrite case in a few cycles. The contents of the save registers are read only through returns.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [2:0] C_PAGE = 3'd1;
  localparam logic [2:0] C_ABS  = 3'd2;
  localparam logic [2:0] C_CALL = 3'd3;
  localparam logic [2:0] C_RET  = 3'd4;

  logic [ADDR_W-1:0] pc, save0, save1, pc_inc, pc_nxt;

  assign pc_inc = pc + 1'b1;
  assign pc_o   = pc;

  always_comb begin
    case (cmd)
      C_PAGE:  pc_nxt = {pc[ADDR_W-1:PAGE_W], target[PAGE_W-1:0]};
      C_ABS,
      C_CALL:  pc_nxt = target;
      C_RET:   pc_nxt = save0;
      default: pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      save0 <= '0;
      save1 <= '0;
    end else if (step_en) begin
      pc <= pc_nxt;
      if (cmd == C_CALL) begin
        save1 <= save0;
        save0 <= pc_inc;
      end else if (cmd == C_RET) begin
        save0 <= save1;
      end
    end
  end
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] target,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] save0,
  input logic [ADDR_W-1:0] save1
);
  logic [ADDR_W-1:0] inc_v;
  assign inc_v = pc_o + 1'b1;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (pc_o == '0 && save0 == '0 && save1 == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !step_en |=> ($stable(pc_o) && $stable(save0) && $stable(save1))); // R2
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst) (step_en && (cmd == 3'd0 || cmd > 3'd4)) |=> pc_o == $past(inc_v)); // R3
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst) (step_en && cmd == 3'd1) |=> (pc_o[ADDR_W-1:PAGE_W] == $past(pc_o[ADDR_W-1:PAGE_W]) && pc_o[PAGE_W-1:0] == $past(target[PAGE_W-1:0]))); // R4
  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (rst) (step_en && cmd == 3'd2) |=> pc_o == $past(target)); // R5
  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst) (step_en && cmd == 3'd3) |=> (pc_o == $past(target) && save0 == $past(inc_v) && save1 == $past(save0))); // R6
  AST_RET_POP: assert property (@(posedge clk) disable iff (rst) (step_en && cmd == 3'd4) |=> (pc_o == $past(save0) && save0 == $past(save1) && $stable(save1))); // R7
endmodule

bind pc_seq pc_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .cmd(cmd), .target(target),
  .pc_o(pc_o), .save0(save0), .save1(save1)
);

// File: tb/sim_pc_seq.sv
module sim_pc_seq;
  logic       clk = 0;
  logic       rst = 1;
  logic       step_en = 0;
  logic [2:0] cmd = 0;
  logic [8:0] target = 0;
  logic [8:0] pc_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pc_seq u0 (.clk(clk), .rst(rst), .step_en(step_en), .cmd(cmd), .target(target), .pc_o(pc_o));

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic op(input logic [2:0] c, input logic [8:0] t);
    @(negedge clk);
    step_en = 1; cmd = c; target = t;
    @(negedge clk);
    step_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; step_en = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc after reset", pc_o, 9'h000);
    op(3'd2, 9'h055);
    do_reset();
    op(3'd4, 9'h1FF);
    chk("R1 return after reset", pc_o, 9'h000);
  endtask

  task automatic t_hold();
    op(3'd2, 9'h040);
    @(negedge clk); cmd = 3'd3; target = 9'h1FF;
    @(negedge clk); @(negedge clk);
    chk("R2 hold while disabled", pc_o, 9'h040);
    op(3'd4, 9'h000);
    chk("R2 no push while disabled", pc_o, 9'h000);
  endtask

  task automatic t_step();
    op(3'd2, 9'h1FE);
    chk("R5 absolute jump", pc_o, 9'h1FE);
    op(3'd0, 9'h000);
    chk("R3 step", pc_o, 9'h1FF);
    op(3'd0, 9'h123);
    chk("R3 wrap", pc_o, 9'h000);
  endtask

  task automatic t_page();
    op(3'd2, 9'h0C5);
    op(3'd1, 9'h1AB);
    chk("R4 page jump", pc_o, (9'h0C5 & 9'h1C0) | (9'h1AB & 9'h03F));
  endtask

  task automatic t_nest();
    do_reset();
    op(3'd2, 9'h010);
    op(3'd3, 9'h100);
    chk("R6 call target", pc_o, 9'h100);
    op(3'd0, 9'h000);
    op(3'd3, 9'h150);
    op(3'd4, 9'h000);
    chk("R7 inner return", pc_o, 9'h102);
    op(3'd4, 9'h000);
    chk("R8 outer return", pc_o, 9'h011);
  endtask

  task automatic t_overflow();
    do_reset();
    op(3'd2, 9'h020);
    op(3'd3, 9'h080);
    op(3'd3, 9'h0A0);
    op(3'd3, 9'h0C0);
    op(3'd4, 9'h000);
    chk("R9 newest", pc_o, 9'h0A1);
    op(3'd4, 9'h000);
    chk("R9 middle", pc_o, 9'h081);
    op(3'd4, 9'h000);
    chk("R9 middle again", pc_o, 9'h081);
  endtask

  task automatic t_call_wrap();
    op(3'd2, 9'h1FF);
    op(3'd3, 9'h033);
    op(3'd4, 9'h000);
    chk("R6 return address wraps", pc_o, 9'h000);
  endtask

  task automatic t_unused();
    op(3'd2, 9'h077);
    for (int c = 5; c < 8; c++) begin
      op(c[2:0], 9'h1C3);
      chk("R10 unused code steps", pc_o, 9'h078 + 9'(c - 5));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_step();
    t_page();
    t_nest();
    t_overflow();
    t_call_wrap();
    t_unused();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule